// File: doc/BRIEF.md
# Instruction-Cache Invalidate-All Outcome Arbiter

This block sits beside the system-register access path of a processor core. When a move-to-coprocessor request arrives, it checks whether the encoding names the operation that invalidates every instruction cache of the executing core up to the point of unification. If it does, the block picks one outcome for that request. The choice depends on the current exception level, on flags that say which features are present, on the register width the hypervisor level runs in, and on the hypervisor trap controls.

The outcome is registered. One cycle after the request, a single valid pulse comes out together with a one-hot kind vector. The possible kinds are undefined-instruction, no-op, a trap to a 64-bit hypervisor, a trap to a 32-bit hypervisor, a local invalidate, or a broadcast invalidate. Alongside the kind come a trap syndrome class and a branch-predictor flush request.

The caller computes two helper conditions, trap eligibility and treat-as-no-op, and supplies them as plain inputs. The cache arrays, the predictor storage and exception entry all live outside this block.

Top module: `icinv_trap_arb`

## Requirements
- R1: An outcome is produced only for a valid write request whose fields are coprocessor 15, first opcode 0, primary register 7, secondary register 5 and second opcode 0. A read, or any other field value, gives no valid outcome.
- R2: The outcome is undefined (kind bit 0) when the 32-bit EL1 feature flag is clear or when the current level (`cur_el`, 0 to 3) is 0.
- R3: At EL1, a low trap-eligibility input gives no-op (kind bit 1), whatever the trap controls are.
- R4: At EL1, with the hypervisor enabled, a 64-bit hypervisor present and the hypervisor in 64-bit mode, any of the group-7 trap, PoU-trap or other-unification-trap controls gives a 64-bit-style trap (kind bit 2) with syndrome class 0x03.
- R5: At EL1, with the hypervisor enabled, a 32-bit hypervisor present and the hypervisor in 32-bit mode, the same three controls give a 32-bit-style trap (kind bit 3) with syndrome class 0x03.
- R6: When `hyp_en` is low, EL1 ignores every trap control and goes straight to the no-op/invalidate decision. A non-trap outcome carries syndrome 0.
- R7: When no earlier rule applies, a high treat-as-no-op input gives no-op, and a low one gives a local invalidate (kind bit 4).
- R8: At EL2, a low trap-eligibility input gives no-op, and the trap controls are never consulted.
- R9: At EL3, both trap eligibility and the trap controls are ignored. Only treat-as-no-op decides.
- R10: At non-secure EL1, a set force-broadcast control turns an invalidate into a broadcast invalidate (kind bit 5). At secure EL1, EL2 and EL3 it has no effect.
- R11: The branch-predictor flush output is high exactly when the outcome is an invalidate (either kind) and predictors are marked visible.
- R12: The source-register data input has no effect on any output.
- R13: Outputs appear on the clock edge after the request. The valid signal is a single-cycle pulse per request. When valid is high exactly one kind bit is set, and when it is low all kind bits are zero. Synchronous active-high reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = move to coprocessor (write) |
| req_coproc | input | 4 | Coprocessor number |
| req_op1 | input | 3 | First opcode field |
| req_crn | input | 4 | Primary register field |
| req_crm | input | 4 | Secondary register field |
| req_op2 | input | 3 | Second opcode field |
| req_data | input | 32 | Source register value (ignored) |
| cur_el | input | 2 | Current exception level |
| feat_el1_a32 | input | 1 | 32-bit EL1 implemented |
| hyp_en | input | 1 | Hypervisor level enabled |
| hyp_a64_impl | input | 1 | 64-bit hypervisor implemented |
| hyp_a32_impl | input | 1 | 32-bit hypervisor implemented |
| hyp_is_a32 | input | 1 | Hypervisor runs in 32-bit mode |
| nonsecure | input | 1 | Current state is non-secure |
| trap_grp7 | input | 1 | Trap coprocessor group 7 control |
| trap_pou | input | 1 | Trap PoU maintenance control |
| trap_ocu | input | 1 | Trap other cache-to-unification control |
| force_bcast | input | 1 | Force broadcast control |
| trap_ok | input | 1 | Trap eligibility helper |
| treat_nop | input | 1 | Treat-as-no-op helper |
| bp_visible | input | 1 | Branch predictors architecturally visible |
| out_valid | output | 1 | Outcome strobe |
| out_kind | output | 6 | One-hot: 0 undef, 1 nop, 2 trap64, 3 trap32, 4 local inval, 5 broadcast inval |
| out_bp_flush | output | 1 | Branch-predictor flush request |
| out_syndrome | output | 6 | Trap syndrome class (0x03 on trap, else 0) |

## Verification
The bench aims at the points where the priority chain can go wrong:
- A low trap eligibility must beat set trap controls at EL1. A design that checked the traps first would report a trap there.
- Trap controls left set at EL2 and EL3 must not matter. A design that leaked them would trap at the wrong level.
- The two trap styles must follow the hypervisor width mode. A design that mixed them up would show the wrong kind bit.
- With the hypervisor disabled, a design that ignored `hyp_en` would trap when it should invalidate.
- Force-broadcast must apply only at non-secure EL1. A design that applied it more widely would show broadcast at secure EL1 or at EL2.

It also sends near-miss encodings and read requests, which must produce no strobe, and varies the ignored data word.

// File: rtl/icinv_trap_arb.sv
module icinv_trap_arb #(
  parameter int SYN_W = 6,
  parameter logic [SYN_W-1:0] TRAP_EC = 6'h03
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [3:0]       req_coproc,
  input  logic [2:0]       req_op1,
  input  logic [3:0]       req_crn,
  input  logic [3:0]       req_crm,
  input  logic [2:0]       req_op2,
  input  logic [31:0]      req_data,
  input  logic [1:0]       cur_el,
  input  logic             feat_el1_a32,
  input  logic             hyp_en,
  input  logic             hyp_a64_impl,
  input  logic             hyp_a32_impl,
  input  logic             hyp_is_a32,
  input  logic             nonsecure,
  input  logic             trap_grp7,
  input  logic             trap_pou,
  input  logic             trap_ocu,
  input  logic             force_bcast,
  input  logic             trap_ok,
  input  logic             treat_nop,
  input  logic             bp_visible,
  output logic             out_valid,
  output logic [5:0]       out_kind,
  output logic             out_bp_flush,
  output logic [SYN_W-1:0] out_syndrome
);
  localparam int K_UND = 0, K_NOP = 1, K_T64 = 2, K_T32 = 3, K_INV = 4, K_BC = 5;

  logic hit, h64, h32, unused_ok;
  logic [5:0] kind;

  assign hit = req_valid && req_write && req_coproc == 4'hF && req_op1 == 3'd0 &&
               req_crn == 4'd7 && req_crm == 4'd5 && req_op2 == 3'd0;
  assign h64 = hyp_en && hyp_a64_impl && !hyp_is_a32;
  assign h32 = hyp_en && hyp_a32_impl &&  hyp_is_a32;
  assign unused_ok = ^req_data;

  always_comb begin
    kind = '0;
    if (!feat_el1_a32 || cur_el == 2'd0)        kind[K_UND] = 1'b1;
    else if (cur_el == 2'd1) begin
      if (!trap_ok)                             kind[K_NOP] = 1'b1;
      else if (h64 && trap_grp7)                kind[K_T64] = 1'b1;
      else if (h32 && trap_grp7)                kind[K_T32] = 1'b1;
      else if (h64 && trap_pou)                 kind[K_T64] = 1'b1;
      else if (h64 && trap_ocu)                 kind[K_T64] = 1'b1;
      else if (h32 && trap_pou)                 kind[K_T32] = 1'b1;
      else if (h32 && trap_ocu)                 kind[K_T32] = 1'b1;
      else if (treat_nop)                       kind[K_NOP] = 1'b1;
      else if (nonsecure && force_bcast)        kind[K_BC]  = 1'b1;
      else                                      kind[K_INV] = 1'b1;
    end
    else if (cur_el == 2'd2 && !trap_ok)        kind[K_NOP] = 1'b1;
    else if (treat_nop)                         kind[K_NOP] = 1'b1;
    else                                        kind[K_INV] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_kind     <= '0;
      out_bp_flush <= 1'b0;
      out_syndrome <= '0;
    end else begin
      out_valid    <= hit;
      out_kind     <= hit ? kind : '0;
      out_bp_flush <= hit && (kind[K_INV] || kind[K_BC]) && bp_visible;
      out_syndrome <= (hit && (kind[K_T64] || kind[K_T32])) ? TRAP_EC : '0;
    end
  end

  a_r13_onehot: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones(out_kind) == 1);
  a_r13_idle: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> out_kind == '0);
  a_r13_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(req_valid));
  a_r2_el0_undef: assert property (@(posedge clk) disable iff (rst)
    (req_valid && hit && cur_el == 2'd0) |=> out_kind[K_UND]);
  a_r4_syndrome: assert property (@(posedge clk) disable iff (rst)
    (out_kind[K_T64] || out_kind[K_T32]) |-> out_syndrome == TRAP_EC);
  a_r11_flush: assert property (@(posedge clk) disable iff (rst)
    out_bp_flush |-> (out_kind[K_INV] || out_kind[K_BC]));
  a_r9_el3_no_trap: assert property (@(posedge clk) disable iff (rst)
    (hit && cur_el == 2'd3) |=> !(out_kind[K_T64] || out_kind[K_T32] || out_kind[K_BC]));
endmodule

// File: tb/sim_icinv_trap_arb.sv
module sim_icinv_trap_arb;
  logic clk = 0, rst = 1;
  always #5 clk = ~clk;

  logic v, wr, ns, fa, he, h64, h32, ua, g7, tpu, tocu, fb, tok, tn, bpv;
  logic [3:0] cp, cn, cm;
  logic [2:0] o1, o2;
  logic [1:0] el;
  logic [31:0] rt;
  logic out_valid, out_bp_flush;
  logic [5:0] out_kind, out_syndrome;
  int n_run = 0, n_fail = 0;

  icinv_trap_arb u0 (.clk(clk), .rst(rst), .req_valid(v), .req_write(wr), .req_coproc(cp),
    .req_op1(o1), .req_crn(cn), .req_crm(cm), .req_op2(o2), .req_data(rt), .cur_el(el),
    .feat_el1_a32(fa), .hyp_en(he), .hyp_a64_impl(h64), .hyp_a32_impl(h32), .hyp_is_a32(ua),
    .nonsecure(ns), .trap_grp7(g7), .trap_pou(tpu), .trap_ocu(tocu), .force_bcast(fb),
    .trap_ok(tok), .treat_nop(tn), .bp_visible(bpv), .out_valid(out_valid),
    .out_kind(out_kind), .out_bp_flush(out_bp_flush), .out_syndrome(out_syndrome));

  localparam int NONE = 6;

  function automatic int model();
    bit any;
    if (!(v && wr && cp == 15 && o1 == 0 && cn == 7 && cm == 5 && o2 == 0)) return NONE;
    if (!fa || el == 0) return 0;
    any = g7 || tpu || tocu;
    if (el == 1) begin
      if (!tok) return 1;
      if (he && h64 && !ua && any) return 2;
      if (he && h32 && ua && any) return 3;
      if (tn) return 1;
      return (ns && fb) ? 5 : 4;
    end
    if (el == 2 && !tok) return 1;
    return tn ? 1 : 4;
  endfunction

  task automatic step(input string tag);
    int c;
    logic [5:0] ek, es;
    logic ef;
    c = model();
    ek = (c == NONE) ? 6'd0 : 6'(1 << c);
    ef = (c == 4 || c == 5) && bpv;
    es = (c == 2 || c == 3) ? 6'h03 : 6'h00;
    @(negedge clk);
    n_run++;
    if (out_valid !== (c != NONE) || out_kind !== ek || out_bp_flush !== ef || out_syndrome !== es) begin
      n_fail++;
      $display("FAIL %s: got v=%b k=%b f=%b s=%h exp v=%b k=%b f=%b s=%h", tag,
        out_valid, out_kind, out_bp_flush, out_syndrome, c != NONE, ek, ef, es);
    end
  endtask

  task automatic base();
    v = 1; wr = 1; cp = 4'hF; o1 = 0; cn = 7; cm = 5; o2 = 0; rt = 0;
    el = 1; fa = 1; he = 1; h64 = 1; h32 = 1; ua = 0; ns = 1;
    g7 = 0; tpu = 0; tocu = 0; fb = 0; tok = 1; tn = 0; bpv = 0;
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    base(); v = 0;
    repeat (3) @(negedge clk);
    n_run++;
    if (out_valid !== 0 || out_kind !== 0) begin
      n_fail++; $display("FAIL R13 reset: got v=%b k=%b exp 0 0", out_valid, out_kind);
    end
    rst = 0;
    base(); step("R7 local invalidate");
    base(); cm = 4'd6; step("R1 wrong crm");
    base(); wr = 0; step("R1 read direction");
    base(); o2 = 3'd1; step("R1 wrong op2");
    base(); el = 0; step("R2 EL0");
    base(); fa = 0; el = 3; step("R2 feature clear");
    base(); tok = 0; g7 = 1; step("R3 eligibility first");
    base(); g7 = 1; step("R4 grp7 64");
    base(); tocu = 1; step("R4 ocu 64");
    base(); ua = 1; tpu = 1; step("R5 pou 32");
    base(); ua = 1; h32 = 0; tpu = 1; step("R5 32 absent");
    base(); he = 0; g7 = 1; tpu = 1; step("R6 hyp disabled");
    base(); tn = 1; step("R7 treat nop");
    base(); el = 2; tok = 0; step("R8 EL2 ineligible");
    base(); el = 2; g7 = 1; tpu = 1; tocu = 1; step("R8 EL2 ignores traps");
    base(); el = 3; tok = 0; g7 = 1; step("R9 EL3");
    base(); fb = 1; step("R10 broadcast");
    base(); fb = 1; ns = 0; step("R10 secure");
    base(); fb = 1; el = 2; step("R10 EL2");
    base(); bpv = 1; fb = 1; step("R11 flush bcast");
    base(); bpv = 1; g7 = 1; step("R11 no flush trap");
    base(); rt = 32'hFFFF_FFFF; g7 = 1; step("R12 data ignored");
    base(); v = 0; step("R13 idle");
    for (int i = 0; i < 3000; i++) begin
      base();
      {el, fa, he, h64, h32, ua, ns, g7, tpu, tocu, fb, tok, tn, bpv} = 15'($urandom);
      fa = fa | ($urandom_range(3) != 0);
      {g7, tpu, tocu} = ($urandom_range(1) == 0) ? 3'b0 : {g7, tpu, tocu};
      rt = $urandom; v = ($urandom_range(7) != 0);
      if ($urandom_range(4) == 0) {wr, cp, o1, cn, cm, o2} = 19'($urandom);
      step("R13 random");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule